// File: doc/BRIEF.md
# Up/Down Timer with Falling-Edge Capture

The block is a 16-bit counter/timer that counts up or down on a selected timebase. A falling edge on the capture pin copies the live count into a 16-bit capture register. The timebase is the system clock divided by 12, the system clock divided by 2, or an external clock divided by 8. In counter mode the timer counts falling edges on a count pin instead. One sticky flag records both overflow (0xFFFF to 0x0000) and underflow (0x0000 to 0xFFFF). A second sticky flag records captures. Both flags feed one interrupt request, which an enable bit gates.

The capture pin, the count pin and the external clock each pass through a two-stage synchroniser. Each one then feeds a two-state level tracker. `LVL_HIGH` moves to `LVL_LOW` when the synchronised level reads 0; that transition is the falling-edge event. `LVL_LOW` moves to `LVL_HIGH` when the level reads 1; that transition is the rising-edge event. Every other case holds the state. Because each transition happens once per pin edge, each edge yields exactly one single-cycle event. Software can load the count through a write strobe and clear each flag with its own write-one-to-clear strobe.

Top module: `updn_capture_timer`

## Requirements
- R1: After reset, count and capture are 0x0000, and both flags and the interrupt are 0.
- R2: With `dec_en`=0, each count event while running adds 1. Stepping from 0xFFFF to 0x0000 sets `ovf_flag`.
- R3: With `dec_en`=1, each count event while running subtracts 1. Stepping from 0x0000 to 0xFFFF sets the same `ovf_flag`.
- R4: While `run_en`=0 the count does not change, except through a software write.
- R5: With `cnt_mode`=0, `clk_sel` picks the timebase: 0 gives one event every 12 system clocks, 1 gives one every 2, and 2 gives one every 8 rising edges of `ext_clk`. Value 3 behaves as 0.
- R6: With `cap_mode`=1 and `ext_en`=1, a falling edge on `cap_pin` loads the count into `capture` and sets `ext_flag`. Both are visible after the third rising clock edge that follows the pin change.
- R7: When `ext_en`=0 or `cap_mode`=0, edges on `cap_pin` change neither `capture` nor `ext_flag`.
- R8: When a capture and a count event fall in the same cycle, `capture` receives the count as it was before that cycle's step.
- R9: A `cnt_wr` strobe loads `cnt_wdata` into the count and takes priority over a count event in the same cycle.
- R10: Each flag stays set until its clear strobe (`ovf_clr`, `exf_clr`) is high for a cycle. A new set in the same cycle wins over the clear.
- R11: `irq` equals (`ovf_flag` OR `ext_flag`) AND `irq_en`.
- R12: With `cnt_mode`=1, each falling edge of `cnt_pin` gives exactly one count, no matter how long the pin stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Run control |
| ext_en | input | 1 | Enables capture-pin events |
| cap_mode | input | 1 | Selects capture mode |
| dec_en | input | 1 | 1 = count down, 0 = count up |
| clk_sel | input | 2 | Timebase select (0: /12, 1: /2, 2: ext/8) |
| cnt_mode | input | 1 | 1 = count falling edges of cnt_pin |
| irq_en | input | 1 | Interrupt enable |
| ext_clk | input | 1 | External clock source |
| cnt_pin | input | 1 | Count-pin input |
| cap_pin | input | 1 | Capture-pin input |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write data |
| ovf_clr | input | 1 | Clears ovf_flag |
| exf_clr | input | 1 | Clears ext_flag |
| count | output | 16 | Current count |
| capture | output | 16 | Captured count |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
Some behaviours are checked on every cycle by assertions. These are the wrap in each direction and the flag it sets, the frozen count while stopped, write priority, the capture register holding between events, the sticky flags, the single-cycle edge events, and the spacing of divide-by-12 ticks. Other behaviours only the scenarios can show. These are the actual divide ratios measured over fixed windows, the three-edge capture latency, the value held in the capture register compared against a predicted count, the pre-step value taken when capture and count coincide, and the absence of any capture while it is disabled.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [1:0] {
        SEL_SLOW = 2'd0,
        SEL_FAST = 2'd1,
        SEL_EXT  = 2'd2,
        SEL_RSVD = 2'd3
    } tsel_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/pin_edge_fsm.sv
module pin_edge_fsm
    import timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    lvl_state_e             st_q, st_d;

    assign lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= {SYNC_STAGES{RESET_LEVEL}};
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_LEVEL ? LVL_HIGH : LVL_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LVL_HIGH: if (!lvl) st_d = LVL_LOW;
            LVL_LOW:  if (lvl)  st_d = LVL_HIGH;
            default:  st_d = LVL_HIGH;
        endcase
    end

    always_comb begin
        fall_o = 1'b0;
        rise_o = 1'b0;
        unique case (st_q)
            LVL_HIGH: fall_o = !lvl;
            LVL_LOW:  rise_o = lvl;
            default: ;
        endcase
    end

    // R12: an edge event never lasts more than one cycle
    assert_single_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
    assert_single_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/tick_gen.sv
module tick_gen
    import timer_pkg::*;
#(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 2,
    parameter int DIV_EXT  = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  tsel_e sel_i,
    input  logic  cnt_mode_i,
    input  logic  ext_rise_i,
    input  logic  pin_fall_i,
    output logic  tick_o
);
    localparam int PW = $clog2(DIV_SLOW);
    localparam int EW = $clog2(DIV_EXT);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] pre_lim;
    logic [EW-1:0] ext_q;
    logic          pre_hit, ext_hit;

    assign pre_lim = (sel_i == SEL_FAST) ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
    assign pre_hit = (pre_q >= pre_lim);
    assign ext_hit = ext_rise_i && (ext_q == EW'(DIV_EXT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_q <= '0;
        else if (pre_hit) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ext_q <= '0;
        else if (ext_rise_i) ext_q <= ext_q + 1'b1;
    end

    always_comb begin
        if (cnt_mode_i) tick_o = pin_fall_i;
        else begin
            unique case (sel_i)
                SEL_EXT:  tick_o = ext_hit;
                SEL_FAST: tick_o = pre_hit;
                default:  tick_o = pre_hit;
            endcase
        end
    end

    // R5: on the slow timebase two ticks are never adjacent
    assert_slow_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !cnt_mode_i && sel_i == SEL_SLOW && $stable(sel_i)) |=> !tick_o);
endmodule

// File: rtl/count_core.sv
module count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         dec_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         cap_evt_i,
    input  logic         ext_en_i,
    input  logic         cap_mode_i,
    input  logic         ovf_clr_i,
    input  logic         exf_clr_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] capture_o,
    output logic         ovf_o,
    output logic         exf_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic step, wrap, cap_fire;

    assign step     = run_i && tick_i && !wr_i;
    assign wrap     = step && (dec_i ? (count_o == '0) : (count_o == MAXV));
    assign cap_fire = cap_evt_i && ext_en_i && cap_mode_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count_o <= '0;
        else if (wr_i) count_o <= wdata_i;
        else if (step) count_o <= dec_i ? count_o - 1'b1 : count_o + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        capture_o <= '0;
        else if (cap_fire) capture_o <= count_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_o <= 1'b0;
            exf_o <= 1'b0;
        end else begin
            if (wrap)           ovf_o <= 1'b1;
            else if (ovf_clr_i) ovf_o <= 1'b0;
            if (cap_fire)       exf_o <= 1'b1;
            else if (exf_clr_i) exf_o <= 1'b0;
        end
    end

    assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !wr_i && !dec_i && count_o == MAXV) |=> (count_o == '0 && ovf_o));
    assert_down_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !wr_i && dec_i && count_o == '0) |=> (count_o == MAXV && ovf_o));
    assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_i) |=> $stable(count_o));
    assert_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt_i |=> $stable(capture_o));
    assert_capture_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exf_o) |-> $past(ext_en_i && cap_mode_i));
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> count_o == $past(wdata_i));
    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);
    assert_exf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exf_o && !exf_clr_i) |=> exf_o);
endmodule

// File: rtl/updn_capture_timer.sv
module updn_capture_timer
    import timer_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 2,
    parameter int DIV_EXT     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         ext_en,
    input  logic         cap_mode,
    input  logic         dec_en,
    input  logic [1:0]   clk_sel,
    input  logic         cnt_mode,
    input  logic         irq_en,
    input  logic         ext_clk,
    input  logic         cnt_pin,
    input  logic         cap_pin,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         ovf_clr,
    input  logic         exf_clr,
    output logic [W-1:0] count,
    output logic [W-1:0] capture,
    output logic         ovf_flag,
    output logic         ext_flag,
    output logic         irq
);
    logic cap_fall, cap_rise_unused;
    logic cnt_fall, cnt_rise_unused;
    logic ext_fall_unused, ext_rise;
    logic tick;

    pin_edge_fsm #(.SYNC_STAGES(SYNC_STAGES), .RESET_LEVEL(1'b1)) u_cap_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(cap_pin),
        .fall_o(cap_fall), .rise_o(cap_rise_unused));

    pin_edge_fsm #(.SYNC_STAGES(SYNC_STAGES), .RESET_LEVEL(1'b1)) u_cnt_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin),
        .fall_o(cnt_fall), .rise_o(cnt_rise_unused));

    pin_edge_fsm #(.SYNC_STAGES(SYNC_STAGES), .RESET_LEVEL(1'b0)) u_ext_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_clk),
        .fall_o(ext_fall_unused), .rise_o(ext_rise));

    tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST), .DIV_EXT(DIV_EXT)) u_tick (
        .clk(clk), .rst_n(rst_n), .sel_i(tsel_e'(clk_sel)), .cnt_mode_i(cnt_mode),
        .ext_rise_i(ext_rise), .pin_fall_i(cnt_fall), .tick_o(tick));

    count_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run_en), .dec_i(dec_en),
        .wr_i(cnt_wr), .wdata_i(cnt_wdata), .cap_evt_i(cap_fall), .ext_en_i(ext_en),
        .cap_mode_i(cap_mode), .ovf_clr_i(ovf_clr), .exf_clr_i(exf_clr),
        .count_o(count), .capture_o(capture), .ovf_o(ovf_flag), .exf_o(ext_flag));

    assign irq = (ovf_flag | ext_flag) & irq_en;

    // R11: the interrupt never rises while interrupts are disabled
    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
endmodule

// File: tb/updn_capture_timer_tb.sv
module updn_capture_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0, ext_en = 1'b0, cap_mode = 1'b0, dec_en = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic        cnt_mode = 1'b0, irq_en = 1'b0;
    logic        ext_clk = 1'b0, cnt_pin = 1'b1, cap_pin = 1'b1;
    logic        cnt_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        ovf_clr = 1'b0, exf_clr = 1'b0;
    logic [15:0] count, capture;
    logic        ovf_flag, ext_flag, irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_q[$];
    logic        ext_on = 1'b0;
    logic [1:0]  ph = '0;
    logic        prev_exf = 1'b0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    updn_capture_timer u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ext_en(ext_en), .cap_mode(cap_mode),
        .dec_en(dec_en), .clk_sel(clk_sel), .cnt_mode(cnt_mode), .irq_en(irq_en),
        .ext_clk(ext_clk), .cnt_pin(cnt_pin), .cap_pin(cap_pin), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr), .exf_clr(exf_clr), .count(count),
        .capture(capture), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq));

    always @(negedge clk) begin
        ph <= ph + 2'd1;
        ext_clk <= ext_on ? ph[1] : 1'b0;
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // monitor: compare each new capture against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ext_flag && !prev_exf) begin
            if (exp_q.size() == 0) check("R7 unexpected capture", 32'(capture), 32'hDEAD);
            else check("R6 capture value", 32'(capture), 32'(exp_q.pop_front()));
        end
        prev_exf <= ext_flag;
    end

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cnt(logic [15:0] v);
        @(negedge clk); cnt_wdata = v; cnt_wr = 1'b1;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic pulse_cnt(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_pin = 1'b0; wait_n(4);
            cnt_pin = 1'b1; wait_n(4);
        end
    endtask

    task automatic pulse_cap(bit expect_cap, logic [15:0] v);
        if (expect_cap) exp_q.push_back(v);
        @(negedge clk); cap_pin = 1'b0; wait_n(4);
        cap_pin = 1'b1; wait_n(4);
    endtask

    task automatic strobe_clr(bit o, bit e);
        @(negedge clk); ovf_clr = o; exf_clr = e;
        @(negedge clk); ovf_clr = 1'b0; exf_clr = 1'b0;
    endtask

    task automatic report;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        logic [15:0] base;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count", 32'(count), 32'h0);
        check("R1 capture", 32'(capture), 32'h0);
        check("R1 flags", {30'd0, ovf_flag, ext_flag}, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        run_en = 1'b1; cnt_mode = 1'b1;
        write_cnt(16'h0010);
        pulse_cnt(3);
        check("R2 up count", 32'(count), 32'h0013);

        @(negedge clk); cnt_pin = 1'b0; wait_n(12);
        cnt_pin = 1'b1; wait_n(4);
        check("R12 one count per edge", 32'(count), 32'h0014);

        write_cnt(16'hFFFF);
        pulse_cnt(1);
        check("R2 wrap value", 32'(count), 32'h0000);
        check("R2 ovf flag", 32'(ovf_flag), 32'h1);
        check("R11 irq masked", 32'(irq), 32'h0);
        irq_en = 1'b1; @(negedge clk);
        check("R11 irq on ovf", 32'(irq), 32'h1);
        wait_n(5);
        check("R10 ovf sticky", 32'(ovf_flag), 32'h1);
        strobe_clr(1'b1, 1'b0);
        check("R10 ovf cleared", 32'(ovf_flag), 32'h0);
        check("R11 irq after clear", 32'(irq), 32'h0);

        dec_en = 1'b1;
        write_cnt(16'h0002);
        pulse_cnt(3);
        check("R3 underflow value", 32'(count), 32'hFFFF);
        check("R3 underflow flag", 32'(ovf_flag), 32'h1);
        strobe_clr(1'b1, 1'b0);
        dec_en = 1'b0;

        run_en = 1'b0;
        pulse_cnt(2);
        check("R4 frozen", 32'(count), 32'hFFFF);
        run_en = 1'b1;

        cap_mode = 1'b1; ext_en = 1'b1;
        write_cnt(16'h1234);
        pulse_cap(1'b1, 16'h1234);
        check("R6 ext flag", 32'(ext_flag), 32'h1);
        check("R11 irq on capture", 32'(irq), 32'h1);
        strobe_clr(1'b0, 1'b1);
        check("R10 ext cleared", 32'(ext_flag), 32'h0);

        // R6 latency: value appears on the third edge after the pin falls
        write_cnt(16'h2222);
        exp_q.push_back(16'h2222);
        @(negedge clk); cap_pin = 1'b0;
        wait_n(2);
        check("R6 no capture before third edge", 32'(ext_flag), 32'h0);
        @(negedge clk);
        check("R6 capture on third edge", 32'(capture), 32'h2222);
        cap_pin = 1'b1; wait_n(4);
        strobe_clr(1'b0, 1'b1);

        ext_en = 1'b0;
        write_cnt(16'h5555);
        pulse_cap(1'b0, 16'h0);
        check("R7 ext_en off flag", 32'(ext_flag), 32'h0);
        check("R7 ext_en off value", 32'(capture), 32'h2222);
        ext_en = 1'b1; cap_mode = 1'b0;
        pulse_cap(1'b0, 16'h0);
        check("R7 cap_mode off flag", 32'(ext_flag), 32'h0);
        check("R7 cap_mode off value", 32'(capture), 32'h2222);
        cap_mode = 1'b1;

        write_cnt(16'h0050);
        exp_q.push_back(16'h0050);
        @(negedge clk); cap_pin = 1'b0; cnt_pin = 1'b0;
        wait_n(4); cap_pin = 1'b1; cnt_pin = 1'b1; wait_n(4);
        check("R8 capture pre-step", 32'(capture), 32'h0050);
        check("R8 count stepped", 32'(count), 32'h0051);
        strobe_clr(1'b0, 1'b1);

        cnt_mode = 1'b0; clk_sel = 2'd1;
        wait_n(4);
        @(negedge clk); cnt_wdata = 16'hABCD; cnt_wr = 1'b1;
        wait_n(2); cnt_wr = 1'b0;
        check("R9 write priority", 32'(count), 32'hABCD);

        wait_n(3); base = count; wait_n(20);
        check("R5 div2 rate", 32'(count - base), 32'd10);
        clk_sel = 2'd0; wait_n(30);
        base = count; wait_n(24);
        check("R5 div12 rate", 32'(count - base), 32'd2);
        clk_sel = 2'd3; wait_n(30);
        base = count; wait_n(48);
        check("R5 sel3 as div12", 32'(count - base), 32'd4);
        ext_on = 1'b1; clk_sel = 2'd2; wait_n(40);
        base = count; wait_n(64);
        check("R5 ext div8 rate", 32'(count - base), 32'd2);
        ext_on = 1'b0;

        check("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        report();
    end
endmodule